// File: doc/BRIEF.md
# Software-Managed Translation Entry Store

This block keeps a small set of address-translation entries for a core whose page tables are walked by software. Each entry is held exactly in the form in which software writes it: a 32-bit control word, a 32-bit page word and two 32-bit physical words. The physical words are an upper address word and a lower word that carries both address and permission bits. Entries sit in one or more arrays. Each array is split into sets chosen by a few bits of the effective address, and each set holds several ways.

An operation is started with a one-cycle `start` pulse while `ready` is high, and only one operation runs at a time. There are five operations. A write stores the input words into an entry. A read loads one entry into the staging outputs. A search walks the candidate ways of one set to find a translation. A bulk flush clears entries in chosen arrays. An address invalidate clears the entries that cover one address. An entry whose lock bit is set survives a flush that checks locks and every address invalidate.

Top module: `soft_tlb`

## Requirements
- R1: After reset `ready` is 1, `hit` is 0, every staging output is zero and every stored word of every entry reads back as zero.
- R2: `start` is taken only in a cycle where `ready` is 1, and `ready` is 0 in the cycle that follows. A `start` given while `ready` is 0 has no effect on any entry.
- R3: A write (opCode 0) stores `inCtrl`, `inPage`, `inPhyHi` and `inPhyLo` unchanged into array `inArray`, way `inWay`, in the set given by `inPage` bits [HASH_LSB +: set bits]. A read (opCode 1) of that array and way, with `addr` selecting the same set, returns the four words unchanged.
- R4: A read sets `outArray` and `outWay` to the array and way that were read. It sets `outVictim` to the way of the most recent write.
- R5: A write into an array whose bit in LOCK_SUPPORT is 0 stores control bit 30 (lock) as 0. All other bits are kept.
- R6: A flush (opCode 3) with `checkLock` = 1 clears control bit 31 (valid) in every entry of the arrays set in `arrMask` whose lock bit is 0. Locked entries and unselected arrays keep their valid bit.
- R7: A flush with `checkLock` = 0 clears the valid bit of every entry in the arrays set in `arrMask`.
- R8: An address invalidate (opCode 4) looks at every way of the set selected by `addr` in each array set in `arrMask`. It clears the valid bit of each such way whose page base equals `addr` masked to that entry's page size, unless the entry is locked.
- R9: A search (opCode 2) matches an entry when all of these hold: the entry is valid; its TID field (control bits [23:16]) is 0 or equals `srchTid`; its space bit (control bit 12) equals `srchSpace`; and its page base (page word with bits [11:0] cleared) equals `addr` masked to the page size. The size code s in control bits [11:8] gives a page size of 1 KiB × 4^s.
- R10: A search tests the set chosen by `addr` one candidate per cycle, with arrays in ascending order and ways in ascending order inside each array. On the first match it sets `hit` to 1 and loads the entry's words, its array and its way into the staging outputs.
- R11: A search with no match sets `hit` to 0 and leaves every staging output unchanged.
- R12: A write, read, flush or invalidate keeps `ready` at 0 for exactly one cycle. A search keeps it at 0 for k+1 cycles when it hits at candidate position k (array × WAYS + way). A search that misses keeps it at 0 for NUM_ARRAYS × WAYS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken when ready) |
| opCode | input | 3 | 0 write, 1 read, 2 search, 3 flush, 4 address invalidate |
| inArray | input | ARR_W | Array for write and read |
| inWay | input | WAY_W | Way for write and read |
| inCtrl | input | 32 | Control word to write |
| inPage | input | 32 | Page word to write; also selects the set for a write |
| inPhyHi | input | 32 | Upper physical word to write |
| inPhyLo | input | 32 | Lower physical and permission word to write |
| addr | input | 32 | Effective address for read set, search and invalidate |
| arrMask | input | NUM_ARRAYS | Array bitmask for flush and invalidate |
| checkLock | input | 1 | Flush spares locked entries when 1 |
| srchTid | input | 8 | Search TID |
| srchSpace | input | 1 | Search address-space value |
| ready | output | 1 | Idle and able to take start |
| hit | output | 1 | Result of the most recent search |
| outCtrl | output | 32 | Staging control word |
| outPage | output | 32 | Staging page word |
| outPhyHi | output | 32 | Staging upper physical word |
| outPhyLo | output | 32 | Staging lower physical word |
| outArray | output | ARR_W | Array of the staged entry |
| outWay | output | WAY_W | Way of the staged entry |
| outVictim | output | WAY_W | Way of the most recent write, set by a read |

## Verification
The hardest case to reach is priority among several matching entries. Two entries must match the same address, and they must lie in the same hashed set but in different arrays and ways. The bench writes a global-TID entry into array 0 way 1 and another into array 1 way 0, both on the same page base. It then checks the winner and the number of busy cycles the search takes. A separate case places a 64 KiB entry and then probes addresses that fall inside its page but hash to another set, so that the set selection, and not the size mask, decides the miss.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;

  localparam int VALID_BIT = 31;
  localparam int LOCK_BIT  = 30;
  localparam int TID_LSB   = 16;
  localparam int TID_W     = 8;
  localparam int SPACE_BIT = 12;
  localparam int SIZE_LSB  = 8;
  localparam int SIZE_W    = 4;
  localparam int BASE_LSB  = 12;

  typedef enum logic [2:0] {
    OP_WRITE  = 3'd0,
    OP_READ   = 3'd1,
    OP_SEARCH = 3'd2,
    OP_FLUSH  = 3'd3,
    OP_INVAL  = 3'd4
  } tlbOp_e;

  typedef struct packed {
    logic capture;
    logic wrEn;
    logic rdEn;
    logic flushEn;
    logic invEn;
    logic srchEnd;
  } tlbStrobe_t;

endpackage

// File: rtl/tlbc_ctrl.sv
module tlbc_ctrl import tlbc_pkg::*; #(
  parameter int NUM_ARRAYS = 2,
  parameter int WAYS       = 2,
  parameter int CUR_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       opCode,
  input  logic             candHit,
  output logic             ready,
  output tlbStrobe_t       str,
  output logic [CUR_W-1:0] cursor
);

  localparam int CANDS = NUM_ARRAYS * WAYS;
  localparam logic [CUR_W-1:0] LAST_CAND = CUR_W'(CANDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_SRCH} ctrlState_e;

  ctrlState_e       state;
  logic [2:0]       opQ;
  logic [CUR_W:0]   busyCnt;
  logic             lastCand;

  assign lastCand = (cursor == LAST_CAND);
  assign ready    = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      opQ    <= '0;
      cursor <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          opQ    <= opCode;
          cursor <= '0;
          state  <= (opCode == OP_SEARCH) ? S_SRCH : S_EXEC;
        end
        S_EXEC: state <= S_IDLE;
        S_SRCH: begin
          if (candHit || lastCand) state <= S_IDLE;
          else                     cursor <= cursor + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    str         = '0;
    str.capture = (state == S_IDLE) && start;
    if (state == S_EXEC) begin
      str.wrEn    = (opQ == OP_WRITE);
      str.rdEn    = (opQ == OP_READ);
      str.flushEn = (opQ == OP_FLUSH);
      str.invEn   = (opQ == OP_INVAL);
    end
    str.srchEnd = (state == S_SRCH) && (candHit || lastCand);
  end

  always_ff @(posedge clk) begin
    if (rst || state == S_IDLE) busyCnt <= '0;
    else                        busyCnt <= busyCnt + 1'b1;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && ready) |=> !ready)
    else $error("start accepted but ready stayed high");

  // R12
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |-> (busyCnt < (CUR_W+1)'(CANDS)))
    else $error("operation exceeded candidate count");

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({str.wrEn, str.rdEn, str.flushEn, str.invEn, str.srchEnd}))
    else $error("more than one operation strobe");

endmodule

// File: rtl/tlbc_dpath.sv
module tlbc_dpath import tlbc_pkg::*; #(
  parameter int NUM_ARRAYS = 2,
  parameter int SETS       = 2,
  parameter int WAYS       = 2,
  parameter int HASH_LSB   = 12,
  parameter logic [NUM_ARRAYS-1:0] LOCK_SUPPORT = '1,
  parameter int ARR_W      = 1,
  parameter int WAY_W      = 1,
  parameter int SET_W      = 1,
  parameter int CUR_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  tlbStrobe_t            str,
  input  logic [CUR_W-1:0]      cursor,
  input  logic [ARR_W-1:0]      inArray,
  input  logic [WAY_W-1:0]      inWay,
  input  logic [31:0]           inCtrl,
  input  logic [31:0]           inPage,
  input  logic [31:0]           inPhyHi,
  input  logic [31:0]           inPhyLo,
  input  logic [31:0]           addr,
  input  logic [NUM_ARRAYS-1:0] arrMask,
  input  logic                  checkLock,
  input  logic [TID_W-1:0]      srchTid,
  input  logic                  srchSpace,
  output logic                  candHit,
  output logic                  hit,
  output logic [31:0]           outCtrl,
  output logic [31:0]           outPage,
  output logic [31:0]           outPhyHi,
  output logic [31:0]           outPhyLo,
  output logic [ARR_W-1:0]      outArray,
  output logic [WAY_W-1:0]      outWay,
  output logic [WAY_W-1:0]      outVictim
);

  localparam int ENTRIES = NUM_ARRAYS * SETS * WAYS;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [31:0] ctrlMem [ENTRIES];
  logic [31:0] pageMem [ENTRIES];
  logic [31:0] hiMem   [ENTRIES];
  logic [31:0] loMem   [ENTRIES];

  logic [31:0]           opAddr, opCtrl, opPage, opHi, opLo;
  logic [ARR_W-1:0]      opArr;
  logic [WAY_W-1:0]      opWay;
  logic [NUM_ARRAYS-1:0] opMask;
  logic                  opCheck;
  logic [TID_W-1:0]      opTid;
  logic                  opSpace;
  logic [WAY_W-1:0]      lastWay;

  function automatic logic [IDX_W-1:0] entIdx(input logic [ARR_W-1:0] a,
                                               input logic [SET_W-1:0] s,
                                               input logic [WAY_W-1:0] w);
    return IDX_W'((int'(a) * SETS + int'(s)) * WAYS + int'(w));
  endfunction

  function automatic logic [31:0] sizeMask(input logic [31:0] c);
    int sh;
    sh = 10 + 2 * int'(c[SIZE_LSB +: SIZE_W]);
    if (sh >= 32) return '0;
    return ~((32'd1 << sh) - 32'd1);
  endfunction

  function automatic logic coversAddr(input logic [31:0] c, input logic [31:0] p,
                                      input logic [31:0] a);
    return (p & ~32'hFFF) == (a & sizeMask(c));
  endfunction

  // operation capture at accept
  always_ff @(posedge clk) begin
    if (rst) begin
      opAddr <= '0; opCtrl <= '0; opPage <= '0; opHi <= '0; opLo <= '0;
      opArr <= '0; opWay <= '0; opMask <= '0; opCheck <= 1'b0;
      opTid <= '0; opSpace <= 1'b0;
    end else if (str.capture) begin
      opAddr <= addr;    opCtrl <= inCtrl;   opPage <= inPage;
      opHi <= inPhyHi;   opLo <= inPhyLo;    opArr <= inArray;
      opWay <= inWay;    opMask <= arrMask;  opCheck <= checkLock;
      opTid <= srchTid;  opSpace <= srchSpace;
    end
  end

  logic [SET_W-1:0] wrSet, adSet;
  logic [IDX_W-1:0] wrIdx, rdIdx, cIdx;
  logic [ARR_W-1:0] cArr;
  logic [WAY_W-1:0] cWay;
  logic [31:0]      wrCtrl, cCtrl, cPage;
  logic [TID_W-1:0] cTid;

  assign wrSet = opPage[HASH_LSB +: SET_W];
  assign adSet = opAddr[HASH_LSB +: SET_W];
  assign wrIdx = entIdx(opArr, wrSet, opWay);
  assign rdIdx = entIdx(opArr, adSet, opWay);
  assign cArr  = ARR_W'(int'(cursor) / WAYS);
  assign cWay  = WAY_W'(int'(cursor) % WAYS);
  assign cIdx  = entIdx(cArr, adSet, cWay);
  assign cCtrl = ctrlMem[cIdx];
  assign cPage = pageMem[cIdx];
  assign cTid  = cCtrl[TID_LSB +: TID_W];

  always_comb begin
    wrCtrl = opCtrl;
    if (!LOCK_SUPPORT[opArr]) wrCtrl[LOCK_BIT] = 1'b0;
  end

  assign candHit = cCtrl[VALID_BIT]
                && ((cTid == '0) || (cTid == opTid))
                && (cCtrl[SPACE_BIT] == opSpace)
                && coversAddr(cCtrl, cPage, opAddr);

  // entry storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        ctrlMem[e] <= '0; pageMem[e] <= '0; hiMem[e] <= '0; loMem[e] <= '0;
      end
    end else begin
      if (str.wrEn) begin
        ctrlMem[wrIdx] <= wrCtrl;
        pageMem[wrIdx] <= opPage;
        hiMem[wrIdx]   <= opHi;
        loMem[wrIdx]   <= opLo;
      end
      if (str.flushEn) begin
        for (int a = 0; a < NUM_ARRAYS; a++)
          for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
              if (opMask[ARR_W'(a)] &&
                  (!opCheck || !ctrlMem[entIdx(ARR_W'(a), SET_W'(s), WAY_W'(w))][LOCK_BIT]))
                ctrlMem[entIdx(ARR_W'(a), SET_W'(s), WAY_W'(w))][VALID_BIT] <= 1'b0;
      end
      if (str.invEn) begin
        for (int a = 0; a < NUM_ARRAYS; a++)
          for (int w = 0; w < WAYS; w++)
            if (opMask[ARR_W'(a)]
                && !ctrlMem[entIdx(ARR_W'(a), adSet, WAY_W'(w))][LOCK_BIT]
                && coversAddr(ctrlMem[entIdx(ARR_W'(a), adSet, WAY_W'(w))],
                              pageMem[entIdx(ARR_W'(a), adSet, WAY_W'(w))], opAddr))
              ctrlMem[entIdx(ARR_W'(a), adSet, WAY_W'(w))][VALID_BIT] <= 1'b0;
      end
    end
  end

  // staging registers
  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0; outCtrl <= '0; outPage <= '0; outPhyHi <= '0; outPhyLo <= '0;
      outArray <= '0; outWay <= '0; outVictim <= '0; lastWay <= '0;
    end else begin
      if (str.wrEn) lastWay <= opWay;
      if (str.rdEn) begin
        outCtrl   <= ctrlMem[rdIdx];
        outPage   <= pageMem[rdIdx];
        outPhyHi  <= hiMem[rdIdx];
        outPhyLo  <= loMem[rdIdx];
        outArray  <= opArr;
        outWay    <= opWay;
        outVictim <= lastWay;
      end
      if (str.srchEnd) begin
        hit <= candHit;
        if (candHit) begin
          outCtrl  <= cCtrl;
          outPage  <= cPage;
          outPhyHi <= hiMem[cIdx];
          outPhyLo <= loMem[cIdx];
          outArray <= cArr;
          outWay   <= cWay;
        end
      end
    end
  end

  // R5
  lock_strip_chk: assert property (@(posedge clk) disable iff (rst)
    str.wrEn |=> (LOCK_SUPPORT[opArr] || !ctrlMem[wrIdx][LOCK_BIT]))
    else $error("lock bit kept in array without lock support");

  for (genvar g = 0; g < ENTRIES; g++) begin : g_lockKeep
    // R6
    flush_lock_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (str.flushEn && opCheck && ctrlMem[g][LOCK_BIT])
        |=> (ctrlMem[g][VALID_BIT] == $past(ctrlMem[g][VALID_BIT])))
      else $error("locked entry lost valid in checked flush");
  end

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb import tlbc_pkg::*; #(
  parameter int NUM_ARRAYS = 2,
  parameter int SETS       = 2,
  parameter int WAYS       = 2,
  parameter int HASH_LSB   = 12,
  parameter logic [NUM_ARRAYS-1:0] LOCK_SUPPORT = '1
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        start,
  input  logic [2:0]                                  opCode,
  input  logic [((NUM_ARRAYS > 1) ? $clog2(NUM_ARRAYS) : 1)-1:0] inArray,
  input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0]  inWay,
  input  logic [31:0]                                 inCtrl,
  input  logic [31:0]                                 inPage,
  input  logic [31:0]                                 inPhyHi,
  input  logic [31:0]                                 inPhyLo,
  input  logic [31:0]                                 addr,
  input  logic [NUM_ARRAYS-1:0]                       arrMask,
  input  logic                                        checkLock,
  input  logic [7:0]                                  srchTid,
  input  logic                                        srchSpace,
  output logic                                        ready,
  output logic                                        hit,
  output logic [31:0]                                 outCtrl,
  output logic [31:0]                                 outPage,
  output logic [31:0]                                 outPhyHi,
  output logic [31:0]                                 outPhyLo,
  output logic [((NUM_ARRAYS > 1) ? $clog2(NUM_ARRAYS) : 1)-1:0] outArray,
  output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0]  outWay,
  output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0]  outVictim
);

  localparam int ARR_W = (NUM_ARRAYS > 1) ? $clog2(NUM_ARRAYS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int CUR_W = $clog2(NUM_ARRAYS * WAYS);

  tlbStrobe_t       str;
  logic [CUR_W-1:0] cursor;
  logic             candHit;

  tlbc_ctrl #(
    .NUM_ARRAYS(NUM_ARRAYS), .WAYS(WAYS), .CUR_W(CUR_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .start(start), .opCode(opCode), .candHit(candHit),
    .ready(ready), .str(str), .cursor(cursor)
  );

  tlbc_dpath #(
    .NUM_ARRAYS(NUM_ARRAYS), .SETS(SETS), .WAYS(WAYS), .HASH_LSB(HASH_LSB),
    .LOCK_SUPPORT(LOCK_SUPPORT), .ARR_W(ARR_W), .WAY_W(WAY_W),
    .SET_W(SET_W), .CUR_W(CUR_W)
  ) i_dpath (
    .clk(clk), .rst(rst), .str(str), .cursor(cursor),
    .inArray(inArray), .inWay(inWay), .inCtrl(inCtrl), .inPage(inPage),
    .inPhyHi(inPhyHi), .inPhyLo(inPhyLo), .addr(addr), .arrMask(arrMask),
    .checkLock(checkLock), .srchTid(srchTid), .srchSpace(srchSpace),
    .candHit(candHit), .hit(hit), .outCtrl(outCtrl), .outPage(outPage),
    .outPhyHi(outPhyHi), .outPhyLo(outPhyLo), .outArray(outArray),
    .outWay(outWay), .outVictim(outVictim)
  );

endmodule

// File: tb/test_soft_tlb.sv
module test_soft_tlb;

  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  opCode = '0;
  logic [0:0]  inArray = '0;
  logic [0:0]  inWay = '0;
  logic [31:0] inCtrl = '0, inPage = '0, inPhyHi = '0, inPhyLo = '0, addr = '0;
  logic [1:0]  arrMask = '0;
  logic        checkLock = 1'b0;
  logic [7:0]  srchTid = '0;
  logic        srchSpace = 1'b0;
  logic        ready, hit;
  logic [31:0] outCtrl, outPage, outPhyHi, outPhyLo;
  logic [0:0]  outArray, outWay, outVictim;

  always #5 clk = ~clk;

  soft_tlb #(.NUM_ARRAYS(2), .SETS(2), .WAYS(2), .HASH_LSB(12),
             .LOCK_SUPPORT(2'b10)) i_soft_tlb (
    .clk(clk), .rst(rst), .start(start), .opCode(opCode), .inArray(inArray),
    .inWay(inWay), .inCtrl(inCtrl), .inPage(inPage), .inPhyHi(inPhyHi),
    .inPhyLo(inPhyLo), .addr(addr), .arrMask(arrMask), .checkLock(checkLock),
    .srchTid(srchTid), .srchSpace(srchSpace), .ready(ready), .hit(hit),
    .outCtrl(outCtrl), .outPage(outPage), .outPhyHi(outPhyHi),
    .outPhyLo(outPhyLo), .outArray(outArray), .outWay(outWay),
    .outVictim(outVictim));

  int errors = 0;
  int checks = 0;
  int busyCyc;

  logic [31:0] mC [NE];
  logic [31:0] mP [NE];
  logic [31:0] mH [NE];
  logic [31:0] mL [NE];
  int mLast;
  logic [31:0] stC, stP, stH, stL;
  int stA, stW, stV;
  logic stHit;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int bIdx(input int a, input int s, input int w);
    return a * 4 + s * 2 + w;
  endfunction

  function automatic logic [31:0] bMask(input logic [31:0] c);
    int sh;
    sh = 10 + 2 * int'(c[11:8]);
    if (sh >= 32) return 32'h0;
    return ~((32'd1 << sh) - 32'd1);
  endfunction

  function automatic logic bMatch(input int i, input logic [31:0] a,
                                  input logic [7:0] t, input logic sp);
    logic [31:0] c;
    c = mC[i];
    return c[31] && (c[23:16] == 8'h0 || c[23:16] == t) && (c[12] == sp)
           && ((mP[i] & 32'hFFFF_F000) == (a & bMask(c)));
  endfunction

  task automatic runOp(input logic [2:0] code);
    opCode = code;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 ready low after accept", {31'b0, ready}, 32'd0);
    busyCyc = 0;
    while (ready !== 1'b1) begin
      busyCyc++;
      @(negedge clk);
    end
  endtask

  task automatic opWrite(input int a, input int w, input logic [31:0] c,
                         input logic [31:0] p, input logic [31:0] h, input logic [31:0] l);
    int i;
    inArray = 1'(a); inWay = 1'(w); inCtrl = c; inPage = p; inPhyHi = h; inPhyLo = l;
    runOp(3'd0);
    chk("R12 write busy", busyCyc, 1);
    i = bIdx(a, int'(p[12]), w);
    mC[i] = (a == 1) ? c : (c & ~32'h4000_0000);
    mP[i] = p; mH[i] = h; mL[i] = l;
    mLast = w;
  endtask

  task automatic opRead(input int a, input int s, input int w);
    int i;
    inArray = 1'(a); inWay = 1'(w); addr = 32'(s) << 12;
    runOp(3'd1);
    chk("R12 read busy", busyCyc, 1);
    i = bIdx(a, s, w);
    stC = mC[i]; stP = mP[i]; stH = mH[i]; stL = mL[i];
    stA = a; stW = w; stV = mLast;
    chk("R3/R5 ctrl word", outCtrl, stC);
    chk("R3 page word", outPage, stP);
    chk("R3 phys hi", outPhyHi, stH);
    chk("R3 phys lo", outPhyLo, stL);
    chk("R4 array", {31'b0, outArray}, 32'(stA));
    chk("R4 way", {31'b0, outWay}, 32'(stW));
    chk("R4 victim", {31'b0, outVictim}, 32'(stV));
  endtask

  task automatic readAll();
    for (int a = 0; a < 2; a++)
      for (int s = 0; s < 2; s++)
        for (int w = 0; w < 2; w++)
          opRead(a, s, w);
  endtask

  task automatic opSearch(input logic [31:0] a, input logic [7:0] t, input logic sp);
    int s, pos, found;
    s = int'(a[12]);
    found = -1; pos = 4;
    for (int ar = 0; ar < 2 && found < 0; ar++)
      for (int w = 0; w < 2 && found < 0; w++)
        if (bMatch(bIdx(ar, s, w), a, t, sp)) begin
          found = bIdx(ar, s, w); pos = ar * 2 + w;
          stA = ar; stW = w;
        end
    addr = a; srchTid = t; srchSpace = sp;
    runOp(3'd2);
    chk("R12 search busy", busyCyc, (found >= 0) ? pos + 1 : 4);
    stHit = (found >= 0);
    if (found >= 0) begin
      stC = mC[found]; stP = mP[found]; stH = mH[found]; stL = mL[found];
    end
    chk("R9/R10/R11 hit flag", {31'b0, hit}, {31'b0, stHit});
    chk("R10/R11 staged ctrl", outCtrl, stC);
    chk("R10/R11 staged page", outPage, stP);
    chk("R10/R11 staged hi", outPhyHi, stH);
    chk("R10/R11 staged lo", outPhyLo, stL);
    chk("R10/R11 staged array", {31'b0, outArray}, 32'(stA));
    chk("R10/R11 staged way", {31'b0, outWay}, 32'(stW));
  endtask

  task automatic opFlush(input logic [1:0] m, input logic ck);
    arrMask = m; checkLock = ck;
    runOp(3'd3);
    chk("R12 flush busy", busyCyc, 1);
    for (int i = 0; i < NE; i++)
      if (m[i / 4] && (!ck || !mC[i][30])) mC[i][31] = 1'b0;
  endtask

  task automatic opInval(input logic [1:0] m, input logic [31:0] a);
    int i;
    arrMask = m; addr = a;
    runOp(3'd4);
    chk("R12 inval busy", busyCyc, 1);
    for (int ar = 0; ar < 2; ar++)
      for (int w = 0; w < 2; w++) begin
        i = bIdx(ar, int'(a[12]), w);
        if (m[ar] && !mC[i][30] && ((mP[i] & 32'hFFFF_F000) == (a & bMask(mC[i]))))
          mC[i][31] = 1'b0;
      end
  endtask

  task automatic fillAll();
    int a, s, w;
    for (int i = 0; i < NE; i++) begin
      a = i / 4; s = (i / 2) % 2; w = i % 2;
      opWrite(a, w,
              32'hC000_0155 | (32'(i + 1) << 16) | (32'(i % 2) << 12),
              (32'h0010_0000 * 32'(i + 1)) | (32'(s) << 12) | 32'h0A5,
              32'h11 * 32'(i), 32'hF000_003F | (32'(i) << 12));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog got=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin mC[i] = '0; mP[i] = '0; mH[i] = '0; mL[i] = '0; end
    mLast = 0; stC = '0; stP = '0; stH = '0; stL = '0; stA = 0; stW = 0; stV = 0; stHit = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'b0, ready}, 32'd1);
    chk("R1 hit", {31'b0, hit}, 32'd0);
    chk("R1 staged ctrl", outCtrl, 32'd0);
    chk("R1 staged page", outPage, 32'd0);
    chk("R1 staged victim", {31'b0, outVictim}, 32'd0);

    // R2: start during a busy search is ignored
    addr = 32'h7777_7000; srchTid = 8'h33; srchSpace = 1'b0; opCode = 3'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after accept", {31'b0, ready}, 32'd0);
    opCode = 3'd0; inArray = 1'b0; inWay = 1'b0; inCtrl = 32'h8000_0100;
    inPage = 32'h0000_0000; inPhyHi = 32'h1; inPhyLo = 32'h2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (ready !== 1'b1) @(negedge clk);
    chk("R11 miss after reset", {31'b0, hit}, 32'd0);
    readAll();  // R1 and R2: every entry still zero

    // R3 R4 R5: write all entries, read them back
    fillAll();
    readAll();
    opWrite(0, 0, 32'hC001_0100, 32'h0900_0000, 32'hAA, 32'hBB);
    opRead(1, 1, 1);  // R4 victim is way 0

    // R9 R10: sweep searches
    fillAll();
    for (int i = 0; i < NE; i++) begin
      logic [31:0] pb;
      pb = mP[i] & 32'hFFFF_F000;
      opSearch(pb | 32'h123, 8'(i + 1), 1'(i % 2));
      opSearch(pb | 32'h456, 8'(i + 2), 1'(i % 2));
      opSearch(pb, 8'(i + 1), 1'(~(i % 2)));
    end

    // R10 priority: two global entries on the same base in set 0
    opWrite(0, 1, 32'h8000_0100, 32'h0800_0000, 32'h5, 32'h6);
    opWrite(1, 0, 32'h8000_0100, 32'h0800_0000, 32'h7, 32'h8);
    opSearch(32'h0800_0456, 8'h77, 1'b0);
    opWrite(0, 1, 32'h0000_0100, 32'h0800_0000, 32'h5, 32'h6);
    opSearch(32'h0800_0456, 8'h77, 1'b0);

    // R9 page size: 64 KiB entry in set 0
    opWrite(1, 1, 32'h8000_0300, 32'h0123_0000, 32'h9, 32'hA);
    opSearch(32'h0123_E000, 8'h00, 1'b0);
    opSearch(32'h0123_D000, 8'h00, 1'b0);
    opSearch(32'h0124_0000, 8'h00, 1'b0);

    // R6 checked flush, R7 unchecked flush
    fillAll();
    opFlush(2'b11, 1'b1);
    readAll();
    opFlush(2'b10, 1'b0);
    readAll();

    // R8 address invalidate
    fillAll();
    opInval(2'b11, mP[5] & 32'hFFFF_F000);
    opInval(2'b01, mP[2] & 32'hFFFF_F000);
    opWrite(1, 0, 32'h8000_0100, 32'h0030_1000, 32'h1, 32'h2);
    opInval(2'b01, 32'h0030_1000);
    opInval(2'b10, 32'h0030_1ABC);
    readAll();
    opSearch(32'h0030_1000, 8'h00, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule